// File: doc/BRIEF.md
# Programmable Shift Clock Pulse Generator

This block drives the line-rate timing strobes of a display panel interface. A free-running line counter, advanced by the internal display clock, wraps to zero at the end of each line. Count zero is the reference point, and every output edge is placed relative to it.

The block has two panel types. With the panel-type bit set, a shift clock pulse goes out on every shift clock output, and all of those outputs carry the same waveform. The pulse rises 0 to 3 clocks after the reference point and stays high for 0 to 31 clocks, as set by two separate fields. With the panel-type bit clear, both fields are ignored and a fixed latch pulse is produced instead. That pulse rises 8 clocks before the reference point and falls at it.

Software writes the settings through a small write port into shadow registers. They are copied to the active set only when the counter wraps, so a line never runs on half-updated settings. A display-mode input holds every output low unless it selects one of the two internal-clock modes.

Top module: `shclk_pulse_gen`

## Requirements
- R1: After a synchronous active-high reset, the rise offset and width are 0, the panel-type bit is 0, the line length is 64 clocks, the line counter is at 0, and all outputs are low.
- R2: The line counter runs 0 to L-1 and then returns to 0, where L is the active line length. A line-length write (select 1, data bits [7:0]) below 40 is stored as 40.
- R3: With the panel-type bit at 1 and an internal-clock mode, the shift outputs are high exactly when the count c satisfies rise <= c < rise + width. The rise offset takes values 0 to 3.
- R4: A width code of 0 produces no shift pulse in the line.
- R5: With the panel-type bit at 0 and an internal-clock mode, the latch output is high for counts L-8 to L-1 and low at count 0. The shift outputs stay low whatever the rise and width fields hold.
- R6: All shift clock outputs carry the same value on every cycle.
- R7: Display-mode codes 1 and 3 force all outputs low. Codes 0 and 2 are the internal-clock modes.
- R8: A write changes only the shadow copy. The active settings take the shadow values at the clock edge where the counter goes from L-1 to 0.
- R9: Write decode. Select 0 is timing, with data bits [4:0] the width and bits [6:5] the rise offset. Select 1 is the line length. Select 2, bit 0, is the panel-type bit. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal display clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| disp_mode | input | 2 | Display mode code |
| shift_clk | output | 2 | Shift clock pulse outputs |
| latch_pulse | output | 1 | Fixed latch pulse output |

## Verification
The outputs are decoded from registered state, so each one follows the count in the same cycle. A display-mode change reaches the outputs within that cycle. A write is captured into the shadow copy at the rising edge where it is presented. It reaches the outputs only from the cycle in which the counter reads 0 after the next wrap, so a write made mid-line leaves the rest of that line unchanged. The bench drives inputs shortly after each rising edge and advances its behavioural model on the rising edge, in the same order as the design. It then compares every output with the model at the falling edge.

// File: rtl/shclk_pkg.sv
package shclk_pkg;

    localparam int RISE_W     = 2;
    localparam int WIDTH_W    = 5;
    localparam int WIDTH_LSB  = 0;
    localparam int RISE_LSB   = 5;
    localparam int LATCH_LEAD = 8;

    typedef struct packed {
        logic [RISE_W-1:0]  rise;
        logic [WIDTH_W-1:0] width;
    } pulse_cfg_t;

    typedef enum logic [1:0] {
        REG_TIMING = 2'd0,
        REG_LINE   = 2'd1,
        REG_PANEL  = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    function automatic logic is_internal(input logic [1:0] mode);
        return (mode == 2'd0) || (mode == 2'd2);
    endfunction

endpackage

// File: rtl/shclk_cfg_regs.sv
module shclk_cfg_regs
    import shclk_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int MIN_LINE = 40,
    parameter int DEF_LINE = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [LEN_W-1:0] wr_data,
    input  logic             load,
    output pulse_cfg_t       act_cfg,
    output logic             act_panel,
    output logic [LEN_W-1:0] act_len
);

    localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LINE);
    localparam logic [LEN_W-1:0] LEN_RESET = LEN_W'(DEF_LINE);

    pulse_cfg_t       shd_cfg;
    logic             shd_panel;
    logic [LEN_W-1:0] shd_len;
    logic [LEN_W-1:0] len_req;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(wr_sel);
    assign len_req = (wr_data < LEN_FLOOR) ? LEN_FLOOR : wr_data;

    // Shadow copy: written from the port (R9), floor on length (R2)
    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg   <= '0;
            shd_panel <= 1'b0;
            shd_len   <= LEN_RESET;
        end else if (wr_en) begin
            case (sel)
                REG_TIMING: shd_cfg <= '{rise:  wr_data[RISE_LSB +: RISE_W],
                                         width: wr_data[WIDTH_LSB +: WIDTH_W]};
                REG_LINE:   shd_len   <= len_req;
                REG_PANEL:  shd_panel <= wr_data[0];
                default:    ;
            endcase
        end
    end

    // Active copy: updated only at the reference point (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg   <= '0;
            act_panel <= 1'b0;
            act_len   <= LEN_RESET;
        end else if (load) begin
            act_cfg   <= shd_cfg;
            act_panel <= shd_panel;
            act_len   <= shd_len;
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r8_hold_mid_line: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(load)) |-> ($stable(act_cfg) && $stable(act_panel) && $stable(act_len)));

    a_r2_len_floor: assert property (@(posedge clk) disable iff (rst)
        act_len >= LEN_FLOOR);

endmodule

// File: rtl/shclk_line_ctr.sv
module shclk_line_ctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] line_len,
    output logic [LEN_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = (cnt == line_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt < line_len);

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/shclk_pulse_shaper.sv
module shclk_pulse_shaper
    import shclk_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int NUM_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LEN_W-1:0]     cnt,
    input  pulse_cfg_t           cfg,
    input  logic                 panel,
    input  logic [LEN_W-1:0]     line_len,
    input  logic [1:0]           disp_mode,
    output logic [NUM_SHIFT-1:0] shift_clk,
    output logic                 latch_pulse
);

    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] cnt_x;
    logic [SUM_W-1:0] rise_x;
    logic [SUM_W-1:0] stop_x;
    logic [LEN_W-1:0] latch_start;
    logic             enabled;
    logic             in_window;
    logic             pulse_on;
    logic             latch_on;

    assign enabled     = is_internal(disp_mode);
    assign cnt_x       = SUM_W'(cnt);
    assign rise_x      = SUM_W'(cfg.rise);
    assign stop_x      = rise_x + SUM_W'(cfg.width);
    assign latch_start = line_len - LEN_W'(LATCH_LEAD);

    // Window [rise, rise+width); empty when width is zero (R3, R4)
    assign in_window = (cnt_x >= rise_x) && (cnt_x < stop_x);
    assign pulse_on  = enabled && panel && in_window;
    // Fixed pulse: rises LATCH_LEAD clocks before wrap, falls at zero (R5)
    assign latch_on  = enabled && !panel && (cnt >= latch_start);

    assign latch_pulse = latch_on;

    // Every shift output carries the same pulse (R6)
    for (genvar gi = 0; gi < NUM_SHIFT; gi++) begin : g_shift
        assign shift_clk[gi] = pulse_on;
    end

    a_r7_quiet_external: assert property (@(posedge clk) disable iff (rst)
        !is_internal(disp_mode) |-> (shift_clk == '0 && !latch_pulse));

    a_r6_outputs_match: assert property (@(posedge clk) disable iff (rst)
        (shift_clk == '0) || (&shift_clk));

    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(latch_pulse && (shift_clk != '0)));

    a_r4_zero_width: assert property (@(posedge clk) disable iff (rst)
        (cfg.width == '0) |-> (shift_clk == '0));

    a_r3_not_before_rise: assert property (@(posedge clk) disable iff (rst)
        shift_clk[0] |-> (cnt_x >= rise_x));

    a_r5_low_at_ref: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !latch_pulse);

endmodule

// File: rtl/shclk_pulse_gen.sv
module shclk_pulse_gen
    import shclk_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int MIN_LINE  = 40,
    parameter int DEF_LINE  = 64,
    parameter int NUM_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [LEN_W-1:0]     wr_data,
    input  logic [1:0]           disp_mode,
    output logic [NUM_SHIFT-1:0] shift_clk,
    output logic                 latch_pulse
);

    pulse_cfg_t       act_cfg;
    logic             act_panel;
    logic [LEN_W-1:0] act_len;
    logic [LEN_W-1:0] cnt;
    logic             wrap;

    shclk_cfg_regs #(
        .LEN_W    (LEN_W),
        .MIN_LINE (MIN_LINE),
        .DEF_LINE (DEF_LINE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .load      (wrap),
        .act_cfg   (act_cfg),
        .act_panel (act_panel),
        .act_len   (act_len)
    );

    shclk_line_ctr #(
        .LEN_W (LEN_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .line_len (act_len),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    shclk_pulse_shaper #(
        .LEN_W     (LEN_W),
        .NUM_SHIFT (NUM_SHIFT)
    ) u_shape (
        .clk         (clk),
        .rst         (rst),
        .cnt         (cnt),
        .cfg         (act_cfg),
        .panel       (act_panel),
        .line_len    (act_len),
        .disp_mode   (disp_mode),
        .shift_clk   (shift_clk),
        .latch_pulse (latch_pulse)
    );

    // R1: after reset the count sits at zero with every output low
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0 && shift_clk == '0 && !latch_pulse));

endmodule

// File: tb/shclk_pulse_gen_test.sv
module shclk_pulse_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] disp_mode = 2'd0;
    logic [1:0] shift_clk;
    logic       latch_pulse;

    always #5 clk = ~clk;

    shclk_pulse_gen uut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .disp_mode   (disp_mode),
        .shift_clk   (shift_clk),
        .latch_pulse (latch_pulse)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Behavioural reference state
    int m_cnt, m_len, s_len, m_rise, s_rise, m_wid, s_wid, m_pan, s_pan;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_len = 64; s_len = 64;
            m_rise = 0; s_rise = 0; m_wid = 0; s_wid = 0; m_pan = 0; s_pan = 0;
        end else begin
            if (m_cnt == m_len - 1) begin
                m_cnt = 0;
                m_len = s_len; m_rise = s_rise; m_wid = s_wid; m_pan = s_pan;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                if (wr_sel == 2'd0) begin
                    s_wid  = wr_data % 32;
                    s_rise = (wr_data / 32) % 4;
                end else if (wr_sel == 2'd1) begin
                    s_len = (wr_data < 40) ? 40 : wr_data;
                end else if (wr_sel == 2'd2) begin
                    s_pan = wr_data % 2;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit internal;
            int e_sh;
            int e_la;
            internal = (disp_mode == 2'd0) || (disp_mode == 2'd2);
            e_sh = (internal && m_pan == 1 && m_cnt >= m_rise && m_cnt < m_rise + m_wid) ? 1 : 0;
            e_la = (internal && m_pan == 0 && m_cnt >= m_len - 8) ? 1 : 0;
            chk(shift_clk[0] == e_sh, tag, "shift_clk[0]", shift_clk[0], e_sh);
            chk(shift_clk[1] == shift_clk[0], "R6", "shift_clk[1]", shift_clk[1], shift_clk[0]);
            chk(latch_pulse == e_la, tag, "latch_pulse", latch_pulse, e_la);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(shift_clk == 2'b00, "R1", "shift after reset", shift_clk, 0);
        chk(latch_pulse == 1'b0, "R1", "latch after reset", latch_pulse, 0);

        tag = "R5"; idle(140);          // fixed pulse, 64-clock lines
        tag = "R2"; wr(2'd1, 8'd20);    // below floor: becomes 40
        idle(100);
        wr(2'd1, 8'd45); idle(100);
        tag = "R5"; wr(2'd0, 8'h65);    // fields set but panel bit 0: ignored
        idle(100);
        tag = "R3"; wr(2'd2, 8'd1);     // panel bit on
        idle(100);
        wr(2'd0, {1'b0, 2'd2, 5'd5}); idle(100);
        wr(2'd0, {1'b0, 2'd3, 5'd31}); idle(100);
        wr(2'd0, {1'b0, 2'd0, 5'd1}); idle(100);
        tag = "R4"; wr(2'd0, {1'b0, 2'd1, 5'd0});
        idle(100);
        tag = "R8"; wr(2'd0, {1'b0, 2'd1, 5'd12});
        idle(20);
        wr(2'd0, {1'b0, 2'd2, 5'd7});   // mid-line: old settings finish the line
        idle(60);
        tag = "R7"; disp_mode = 2'd1; idle(60);
        disp_mode = 2'd3; idle(60);
        tag = "R3"; disp_mode = 2'd2; idle(60);
        tag = "R9"; wr(2'd3, 8'hFF);    // spare select: no effect
        idle(100);
        tag = "R5"; wr(2'd2, 8'd0); idle(100);
        tag = "R7"; disp_mode = 2'd1; idle(60);
        disp_mode = 2'd0;
        tag = "R1"; rst = 1'b1; idle(3); #2 rst = 1'b0;
        @(negedge clk);
        chk(shift_clk == 2'b00, "R1", "shift after second reset", shift_clk, 0);
        chk(latch_pulse == 1'b0, "R1", "latch after second reset", latch_pulse, 0);
        tag = "R5"; idle(70);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule